// File: doc/BRIEF.md
# SPI Byte-Addressed Register File

This block is a serial peripheral slave that gives a host byte-wide access to a 64-entry register space. That space holds the time-keeping, control and scratch bytes of a larger chip. The host lowers the select line and sends one command byte. The top bit of that byte chooses the direction, and the low six bits give the starting location. Any number of data bytes follow. After each data byte the location advances by one, and it wraps from the last entry back to the first.

All serial pins are brought into the fast system clock through two-flop synchronizers. The serial clock edges are then detected in that domain, so the block works with a clock that idles low or idles high. The output enable for the serial data pad stays low until a full read byte is ready to shift out. A power-fail input cancels any transfer in progress, returns the location counter to zero and blocks every write.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset every one of the 64 stored bytes reads back as 8'h00 and `spi_miso_oe` is low.
- R2: The command byte is sampled MSB first on rising serial-clock edges. Bit 7 set to 1 means write and 0 means read. Bit 6 has no effect. Bits 5:0 give the start location.
- R3: In a write, each fully received data byte is stored at the current location, and the location then advances by one, wrapping from 63 to 0.
- R4: In a read, each data byte is driven MSB first, with each bit changing after a falling serial-clock edge. The bytes come from consecutive locations starting at the command location, wrapping from 63 to 0.
- R5: Transfers behave the same whether the serial clock idles low or idles high while the select line is high.
- R6: `spi_miso_oe` is low while the select line is high and during the command byte. In a read it goes high at the first falling edge after the command byte and stays high until deselect.
- R7: A data byte that is cut short by deselect before its eighth bit changes no stored byte.
- R8: After reset, no transfer is accepted until the select line has gone from high to low. A select line already low when reset ends is ignored until it goes high and falls again.
- R9: While `pwr_fail` is high the current transfer ends, the location counter returns to 0, `spi_miso_oe` drops and nothing is written. After `pwr_fail` falls, a fresh high-to-low select is needed before another transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| pwr_fail | input | 1 | Supply-fail flag, synchronous to clk |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad; low means high impedance |

## Verification
The assertions assume that `pwr_fail` is synchronous to `clk`. They also assume that the serial pins change slowly enough that each serial-clock level lasts several system clocks, so every edge is seen exactly once after synchronization. The stimulus changes all serial pins only on falling system-clock edges and holds each serial-clock phase for eight system clocks. It lets the select line settle for several cycles around each transfer. The stimulus mixes random addresses (including bit 6), random burst lengths that wrap the location counter, both clock idle levels, cut-short bytes, a select held low through reset, and supply-fail events during writes and reads.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    // Default geometry of the register space
    localparam int RF_ADDR_W = 6;
    localparam int RF_DATA_W = 8;
    // Positions of the serial pins inside the synchronizer vector
    localparam int PIN_SCK  = 0;
    localparam int PIN_CSN  = 1;
    localparam int PIN_MOSI = 2;
    localparam int PIN_NUM  = 3;
endpackage

// File: rtl/spi_rf_sync.sv
// Two-flop synchronizer with an extra history stage per bit, giving the
// settled level and single-cycle rise/fall pulses in the clk domain.
// Assumes each input level lasts several clk cycles.
module spi_rf_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, sync_q, hist_q;

        // Capture the pin, settle it, and keep one cycle of history
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
                hist_q <= RST_VAL[g];
            end else begin
                meta_q <= pins_in[g];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        assign level[g] = sync_q;
        assign rise[g]  = sync_q & ~hist_q;
        assign fall[g]  = ~sync_q & hist_q;
    end
endmodule

// File: rtl/spi_rf_mem.sv
// Byte storage for the register space: one synchronous write port and one
// combinational read port. Every entry is cleared by reset.
module spi_rf_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    // Clear on reset, otherwise store one byte per write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
        end else if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/spi_rf_frame.sv
// Transfer framing: counts bits, decodes the command byte, advances the
// location counter, issues write strobes and shifts read data out.
// Assumes edge pulses come from spi_rf_sync and pwr_fail is clk-synchronous.
module spi_rf_frame #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_fall,
    input  logic              cs_high,
    input  logic              mosi,
    input  logic              pwr_fail,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso,
    output logic              miso_oe
);
    localparam int                BIT_W    = $clog2(DATA_W);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
    localparam int                DIR_POS  = DATA_W - 1;

    logic              active_q;
    logic              data_phase_q;
    logic              is_write_q;
    logic [BIT_W-1:0]  bit_cnt_q;
    logic [DATA_W-2:0] rx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] tx_q;
    logic              out_bit_q;
    logic              oe_q;

    logic [DATA_W-1:0] byte_in;
    logic              byte_done;

    // Assemble the byte completed by the current rising edge
    always_comb begin
        byte_in   = {rx_q, mosi};
        byte_done = active_q && sck_rise && (bit_cnt_q == LAST_BIT);
        rd_addr   = data_phase_q ? addr_q : byte_in[ADDR_W-1:0];
        wr_en     = byte_done && data_phase_q && is_write_q && !pwr_fail && !cs_high;
        wr_addr   = addr_q;
        wr_data   = byte_in;
    end

    // Transfer state machine: select, command, data bursts and aborts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q     <= 1'b0;
            data_phase_q <= 1'b0;
            is_write_q   <= 1'b0;
            bit_cnt_q    <= '0;
            rx_q         <= '0;
            addr_q       <= '0;
            tx_q         <= '0;
            out_bit_q    <= 1'b0;
            oe_q         <= 1'b0;
        end else if (pwr_fail) begin
            active_q     <= 1'b0;
            data_phase_q <= 1'b0;
            bit_cnt_q    <= '0;
            addr_q       <= '0;
            oe_q         <= 1'b0;
        end else if (cs_high) begin
            active_q     <= 1'b0;
            data_phase_q <= 1'b0;
            bit_cnt_q    <= '0;
            oe_q         <= 1'b0;
        end else if (cs_fall) begin
            active_q     <= 1'b1;
            data_phase_q <= 1'b0;
            bit_cnt_q    <= '0;
            oe_q         <= 1'b0;
        end else if (active_q) begin
            if (sck_rise) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                rx_q      <= byte_in[DATA_W-2:0];
                if (bit_cnt_q == LAST_BIT) begin
                    if (!data_phase_q) begin
                        data_phase_q <= 1'b1;
                        is_write_q   <= byte_in[DIR_POS];
                        if (byte_in[DIR_POS]) begin
                            addr_q <= byte_in[ADDR_W-1:0];
                        end else begin
                            tx_q   <= rd_data;
                            addr_q <= byte_in[ADDR_W-1:0] + 1'b1;
                        end
                    end else begin
                        addr_q <= addr_q + 1'b1;
                        if (!is_write_q) tx_q <= rd_data;
                    end
                end
            end else if (sck_fall && data_phase_q && !is_write_q) begin
                out_bit_q <= tx_q[DATA_W-1];
                tx_q      <= {tx_q[DATA_W-2:0], 1'b0};
                oe_q      <= 1'b1;
            end
        end
    end

    assign miso    = out_bit_q;
    assign miso_oe = oe_q;

    // R6
    oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> active_q);

    // R6
    oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> (data_phase_q && !is_write_q));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

    // R8
    select_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(cs_fall));

    // R9
    pwr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (!active_q && !oe_q && addr_q == '0));

    // R7
    no_partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bit_cnt_q == LAST_BIT && sck_rise));
endmodule

// File: rtl/spi_regfile_slave.sv
// Top of the serial register file: synchronizes the serial pins, frames
// transfers and holds the 64-byte space. Assumes clk runs at least 8x the
// serial clock and pwr_fail is synchronous to clk.
module spi_regfile_slave #(
    parameter int ADDR_W = spi_rf_pkg::RF_ADDR_W,
    parameter int DATA_W = spi_rf_pkg::RF_DATA_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_csn,
    input  logic spi_mosi,
    input  logic pwr_fail,
    output logic spi_miso,
    output logic spi_miso_oe
);
    import spi_rf_pkg::*;

    // Select resets low so a select held low through reset gives no edge
    localparam logic [PIN_NUM-1:0] SYNC_RST = '0;

    logic [PIN_NUM-1:0] pins, lvl, rise, fall;
    logic               wr_en;
    logic [ADDR_W-1:0]  wr_addr, rd_addr;
    logic [DATA_W-1:0]  wr_data, rd_data;
    logic               miso_int, oe_int;

    // Gather the serial pins into one vector for synchronization
    always_comb begin
        pins           = '0;
        pins[PIN_SCK]  = spi_sck;
        pins[PIN_CSN]  = spi_csn;
        pins[PIN_MOSI] = spi_mosi;
    end

    spi_rf_sync #(.WIDTH(PIN_NUM), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (pins),
        .level   (lvl),
        .rise    (rise),
        .fall    (fall)
    );

    spi_rf_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (rise[PIN_SCK]),
        .sck_fall (fall[PIN_SCK]),
        .cs_fall  (fall[PIN_CSN]),
        .cs_high  (lvl[PIN_CSN]),
        .mosi     (lvl[PIN_MOSI]),
        .pwr_fail (pwr_fail),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .miso     (miso_int),
        .miso_oe  (oe_int)
    );

    spi_rf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Drop the pad enable at once on deselect or supply failure
    assign spi_miso    = miso_int;
    assign spi_miso_oe = oe_int && !spi_csn && !pwr_fail;

    // R9
    pwr_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> !wr_en);

    // R6
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_miso_oe);
endmodule

// File: tb/spi_regfile_slave_bench.sv
module spi_regfile_slave_bench;
    localparam int HP    = 32;       // serial half period, 8 system clocks
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, pfail = 1'b0;
    logic miso, miso_oe;

    int checks = 0, fails = 0;
    logic [7:0] model [64];
    logic [7:0] wbuf [16];
    bit done = 0;
    bit mode3 = 0;

    always #2 clk = ~clk;

    spi_regfile_slave u_spi_regfile_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn),
        .spi_mosi(mosi), .pwr_fail(pfail), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Shift nbits of din out MSB first; returns sampled miso bits and oe count
    task automatic spi_bits(input logic [7:0] din, input int nbits,
                            output logic [7:0] dout, output int oe_cnt);
        dout = '0;
        oe_cnt = 0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            mosi = din[i];
            #HP;
            dout[i] = miso;
            oe_cnt += int'(miso_oe);
            sck = 1'b1;
            #HP;
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic sel_begin();
        sck = mode3;
        #(4*HP);
        csn = 1'b0;
        #HP;
    endtask

    task automatic sel_end();
        #HP;
        csn = 1'b1;
        #(2*HP);
        chk("R6 oe after deselect", miso_oe, 1'b0);
    endtask

    // Full burst: write from wbuf or read and compare with the model
    task automatic txn(input bit wr, input logic [6:0] a7, input int n);
        logic [7:0] d;
        int oc;
        int a;
        a = int'(a7[5:0]);
        sel_begin();
        spi_bits({wr, a7}, 8, d, oc);
        chk("R6 oe low in command", oc, 0);
        for (int k = 0; k < n; k++) begin
            spi_bits(wr ? wbuf[k] : 8'h3C, 8, d, oc);
            if (wr) model[(a + k) % 64] = wbuf[k];
            else begin
                chk(mode3 ? "R4 R5 read idle-high" : "R4 R2 read idle-low", d, model[(a + k) % 64]);
                chk("R6 oe during read byte", oc, 8);
            end
        end
        sel_end();
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 64; a += 16) begin
            txn(1'b0, 7'(a), 16);
        end
        checks++;
        if (0) $display("%s", req);
    endtask

    initial begin
        logic [7:0] d;
        int oc;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        // R8: select already low while reset ends
        csn = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 oe at reset", miso_oe, 1'b0);
        rst_n = 1'b1;
        #(4*HP);
        spi_bits(8'h85, 8, d, oc);
        spi_bits(8'hA5, 8, d, oc);
        csn = 1'b1;
        #(4*HP);
        // R1 and R8: everything still zero
        mode3 = 0;
        txn(1'b0, 7'd0, 64);
        // R2 R3: bit 6 ignored, write wraps 62..1
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        txn(1'b1, 7'h7E, 4);
        txn(1'b0, 7'h3E, 4);
        mode3 = 1;
        txn(1'b0, 7'h7F, 2);
        // random bursts in both modes
        for (int t = 0; t < 40; t++) begin
            int n;
            logic [6:0] a7;
            mode3 = $urandom_range(0, 1);
            n = $urandom_range(1, 6);
            a7 = 7'($urandom);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            txn($urandom_range(0, 1) == 1, a7, n);
        end
        // R7: partial byte after a full one is dropped
        mode3 = 0;
        sel_begin();
        spi_bits(8'h8A, 8, d, oc);
        spi_bits(8'h5A, 8, d, oc);
        model[10] = 8'h5A;
        spi_bits(8'hF0, 5, d, oc);
        sel_end();
        txn(1'b0, 7'd10, 2);
        // R9: supply fail in the middle of a write byte
        mode3 = 1;
        sel_begin();
        spi_bits(8'h94, 8, d, oc);
        spi_bits(8'hC3, 4, d, oc);
        pfail = 1'b1;
        #(4*HP);
        pfail = 1'b0;
        #HP;
        spi_bits(8'hC3, 4, d, oc);
        spi_bits(8'h77, 8, d, oc);
        sel_end();
        txn(1'b0, 7'd20, 2);
        // R9: supply fail during a read drops oe and needs a new select
        mode3 = 0;
        sel_begin();
        spi_bits(8'h05, 8, d, oc);
        spi_bits(8'h00, 8, d, oc);
        chk("R9 read before fail", d, model[5]);
        pfail = 1'b1;
        #8;
        chk("R9 oe during fail", miso_oe, 1'b0);
        #(2*HP);
        pfail = 1'b0;
        #(2*HP);
        spi_bits(8'h00, 8, d, oc);
        chk("R9 no oe after fail", oc, 0);
        sel_end();
        check_all("R3 R7 R9 final contents");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule